// File: doc/BRIEF.md
# PCM Serial Clock and Frame Generator

This block is the master-side timing and shifting engine of a PCM audio port. From one system clock it derives a serial bit clock by counting enable ticks from one of two source-clock tick inputs, and groups bit clocks into frames whose length is set by a programmable frame divider. Each frame begins with a one-bit-clock-wide frame-sync pulse. Each frame carries two 16-bit sample words (a left and a right channel), sent MSB first and back to back. A mode input places the first MSB either in the sync bit clock or one bit clock after it.

Transmit words come from a FIFO through a valid/pop handshake. If the FIFO is empty when a word is due, the block sends zeros and flags a starve strobe. Received bits are sampled on the rising edge of the bit clock. Each completed word is presented with a one-cycle strobe. The bit clock runs while either direction is enabled. When both directions are off it stops, unless continuous-clock mode is chosen.

Top module: `pcm_framer`

## Requirements
- R1: The bit clock `sclkOut` is low out of reset and whenever it is not running. While running, its period is 2 × (`sclkDiv` + 1) ticks of the selected source.
- R2: `srcSel` = 0 counts ticks on `srcTickA`. `srcSel` = 1 counts ticks on `srcTickB`.
- R3: A frame is `syncDiv` + 1 bit clocks long. `fsyncOut` is high for exactly the first bit clock of each frame, and only while at least one direction is enabled.
- R4: Each frame carries two 16-bit words, MSB first, in 32 consecutive bit clocks. They start in bit clock 0 of the frame when `msbLate` = 0 and in bit clock 1 when `msbLate` = 1. `sdOut` changes only while `sclkOut` is low (at the falling edge) and is 0 outside the 32 data bit clocks.
- R5: With `txOn` = 1 and `txValid` = 1 at a word's MSB time, the block transmits `txData` and pulses `txReady` for one cycle.
- R6: With `txOn` = 1 and `txValid` = 0 at a word's MSB time, the word is sent as zeros, `txStarve` pulses for one cycle and `txReady` stays low.
- R7: `sdIn` is sampled at each rising edge of the bit clock inside the data window. After the 16th bit of a word, `wordStb` pulses for one cycle. If `rxOn` = 1, `rxData` then holds the word (first bit received in bit 15). `rxData` changes at no other time.
- R8: With `sclkEn` = 0 the bit clock stays low and no frame sync is produced.
- R9: With both directions off, the bit clock stops when `contClk` = 0. It keeps running, without frame sync, when `contClk` = 1.
- R10: Turning one direction off leaves the bit clock and frame timing of the other running. With `txOn` = 0, no word is popped and `sdOut` sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTickA | input | 1 | Tick enable of source clock A |
| srcTickB | input | 1 | Tick enable of source clock B |
| srcSel | input | 1 | 0 selects source A, 1 selects source B |
| sclkEn | input | 1 | Bit-clock enable |
| contClk | input | 1 | Keep the bit clock running when both directions are off |
| txOn | input | 1 | Transmit direction enable |
| rxOn | input | 1 | Receive direction enable |
| msbLate | input | 1 | 1: MSB one bit clock after sync; 0: MSB with sync |
| sclkDiv | input | DIV_W | Bit-clock divider value |
| syncDiv | input | DIV_W | Frame length minus one, in bit clocks |
| txData | input | WORD_W | Transmit word from FIFO |
| txValid | input | 1 | Transmit FIFO holds a word |
| txReady | output | 1 | One-cycle pop of the transmit FIFO |
| txStarve | output | 1 | One-cycle strobe: word due while FIFO empty |
| sdIn | input | 1 | Serial data in |
| rxData | output | WORD_W | Last received word |
| wordStb | output | 1 | One-cycle strobe at each word completion |
| sclkOut | output | 1 | Serial bit clock |
| fsyncOut | output | 1 | Frame sync |
| sdOut | output | 1 | Serial data out |

## Verification
The bench builds the block with its default parameters: 9-bit dividers, 16-bit words and two words per frame. At these values, frames of 32 to 41 bit clocks reach the tight boundaries where the 32-bit data window ends on the last bit clock, in both alignment modes. Source A ticks every cycle and source B every third cycle, so the measured period separates the two sources. Loopback of `sdOut` into `sdIn` lets each received word be checked against the transmitted sequence.

// File: rtl/pcm_framer_pkg.sv
package pcm_framer_pkg;

  // strobes handed from the timing control to the shifting datapath
  typedef struct packed {
    logic idle;       // bit clock stopped: clear datapath state
    logic active;     // at least one direction enabled
    logic shift;      // a new bit clock slot starts (falling edge or start)
    logic frameHead;  // the new slot is the first of a frame
    logic loadWord;   // the new slot carries a word MSB
    logic inWindow;   // the new slot lies in the data window
    logic sample;     // rising edge of the bit clock
    logic sampleWin;  // current slot lies in the data window
    logic lastBit;    // current slot carries a word LSB
  } ctlStrobe_t;

endpackage

// File: rtl/pcm_framer_ctrl.sv
module pcm_framer_ctrl
  import pcm_framer_pkg::*;
#(
  parameter int DIV_W  = 9,
  parameter int WORD_W = 16,
  parameter int WORDS  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcTickA,
  input  logic             srcTickB,
  input  logic             srcSel,
  input  logic             sclkEn,
  input  logic             contClk,
  input  logic             txOn,
  input  logic             rxOn,
  input  logic             msbLate,
  input  logic [DIV_W-1:0] sclkDiv,
  input  logic [DIV_W-1:0] syncDiv,
  output logic             sclkOut,
  output ctlStrobe_t       ctl
);

  localparam int WIN   = WORD_W * WORDS;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int REL_W = DIV_W + 1;

  logic             tick, active, run;
  logic             startStb, edgeHit, riseStb, fallStb;
  logic             running, sclkQ;
  logic [DIV_W-1:0] divCnt, slot, nextSlot;
  logic [REL_W-1:0] relNext, relCur;
  logic             winNext, winCur;

  always_comb begin
    tick     = srcSel ? srcTickB : srcTickA;
    active   = txOn | rxOn;
    run      = sclkEn && (active || contClk);
    startStb = run && !running;
    edgeHit  = run && running && tick && (divCnt >= sclkDiv);
    riseStb  = edgeHit && !sclkQ;
    fallStb  = edgeHit && sclkQ;

    if (startStb || (slot >= syncDiv)) nextSlot = '0;
    else                               nextSlot = slot + 1'b1;

    relNext = {1'b0, nextSlot} - REL_W'(msbLate);
    relCur  = {1'b0, slot} - REL_W'(msbLate);
    winNext = (nextSlot >= DIV_W'(msbLate)) && (relNext < REL_W'(WIN));
    winCur  = (slot >= DIV_W'(msbLate)) && (relCur < REL_W'(WIN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      sclkQ   <= 1'b0;
      divCnt  <= '0;
      slot    <= '0;
    end else if (!run) begin
      running <= 1'b0;
      sclkQ   <= 1'b0;
      divCnt  <= '0;
      slot    <= '0;
    end else begin
      running <= 1'b1;
      if (startStb) begin
        divCnt <= '0;
        sclkQ  <= 1'b0;
        slot   <= '0;
      end else if (tick) begin
        if (divCnt >= sclkDiv) begin
          divCnt <= '0;
          sclkQ  <= ~sclkQ;
          if (sclkQ) slot <= nextSlot;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sclkOut = sclkQ;

  always_comb begin
    ctl.idle      = !run;
    ctl.active    = active;
    ctl.shift     = startStb || fallStb;
    ctl.frameHead = (nextSlot == '0);
    ctl.inWindow  = winNext;
    ctl.loadWord  = winNext && (relNext[BIT_W-1:0] == '0);
    ctl.sample    = riseStb;
    ctl.sampleWin = winCur;
    ctl.lastBit   = (relCur[BIT_W-1:0] == '1);
  end

endmodule

// File: rtl/pcm_framer_dp.sv
module pcm_framer_dp
  import pcm_framer_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              txOn,
  input  logic              rxOn,
  input  logic [WORD_W-1:0] txData,
  input  logic              txValid,
  input  logic              sdIn,
  output logic              fsyncOut,
  output logic              sdOut,
  output logic              txReady,
  output logic              txStarve,
  output logic [WORD_W-1:0] rxData,
  output logic              wordStb
);

  logic [WORD_W-1:0] txSh, rxSh, rxNext;

  assign rxNext = {rxSh[WORD_W-2:0], sdIn};
  assign sdOut  = txSh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsyncOut <= 1'b0;
      txSh     <= '0;
      rxSh     <= '0;
      rxData   <= '0;
      txReady  <= 1'b0;
      txStarve <= 1'b0;
      wordStb  <= 1'b0;
    end else begin
      txReady  <= 1'b0;
      txStarve <= 1'b0;
      wordStb  <= 1'b0;
      if (ctl.idle) begin
        fsyncOut <= 1'b0;
        txSh     <= '0;
        rxSh     <= '0;
      end else begin
        if (ctl.shift) begin
          fsyncOut <= ctl.active && ctl.frameHead;
          if (ctl.loadWord) begin
            if (txOn && txValid) begin
              txSh    <= txData;
              txReady <= 1'b1;
            end else begin
              txSh     <= '0;
              txStarve <= txOn;
            end
          end else if (ctl.inWindow) begin
            txSh <= {txSh[WORD_W-2:0], 1'b0};
          end else begin
            txSh <= '0;
          end
        end else if (!ctl.active) begin
          fsyncOut <= 1'b0;
        end
        if (ctl.sample && ctl.sampleWin) begin
          rxSh <= rxNext;
          if (ctl.lastBit) begin
            wordStb <= ctl.active;
            if (rxOn) rxData <= rxNext;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
  import pcm_framer_pkg::*;
#(
  parameter int DIV_W  = 9,
  parameter int WORD_W = 16,
  parameter int WORDS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcTickA,
  input  logic              srcTickB,
  input  logic              srcSel,
  input  logic              sclkEn,
  input  logic              contClk,
  input  logic              txOn,
  input  logic              rxOn,
  input  logic              msbLate,
  input  logic [DIV_W-1:0]  sclkDiv,
  input  logic [DIV_W-1:0]  syncDiv,
  input  logic [WORD_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txStarve,
  input  logic              sdIn,
  output logic [WORD_W-1:0] rxData,
  output logic              wordStb,
  output logic              sclkOut,
  output logic              fsyncOut,
  output logic              sdOut
);

  ctlStrobe_t ctl;

  pcm_framer_ctrl #(.DIV_W(DIV_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcTickA(srcTickA), .srcTickB(srcTickB),
    .srcSel(srcSel), .sclkEn(sclkEn), .contClk(contClk), .txOn(txOn),
    .rxOn(rxOn), .msbLate(msbLate), .sclkDiv(sclkDiv), .syncDiv(syncDiv),
    .sclkOut(sclkOut), .ctl(ctl)
  );

  pcm_framer_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txOn(txOn), .rxOn(rxOn),
    .txData(txData), .txValid(txValid), .sdIn(sdIn), .fsyncOut(fsyncOut),
    .sdOut(sdOut), .txReady(txReady), .txStarve(txStarve), .rxData(rxData),
    .wordStb(wordStb)
  );

endmodule

// File: rtl/pcm_framer_chk.sv
module pcm_framer_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclkEn,
  input logic              txOn,
  input logic              rxOn,
  input logic              txValid,
  input logic              sclkOut,
  input logic              fsyncOut,
  input logic              sdOut,
  input logic              txReady,
  input logic              txStarve,
  input logic [WORD_W-1:0] rxData,
  input logic              wordStb
);

  assert_sclk_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    !sclkEn |=> !sclkOut);

  assert_fsync_needs_path_R3: assert property (@(posedge clk) disable iff (!rstN)
    fsyncOut |-> $past(txOn || rxOn));

  assert_sdout_moves_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> !sclkOut);

  assert_pop_needs_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> $past(txValid && txOn));

  assert_starve_when_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    txStarve |-> (!$past(txValid) && !txReady));

  assert_word_on_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordStb |-> $rose(sclkOut));

  assert_rxdata_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wordStb |-> $stable(rxData));

endmodule

bind pcm_framer pcm_framer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclkEn(sclkEn), .txOn(txOn), .rxOn(rxOn),
  .txValid(txValid), .sclkOut(sclkOut), .fsyncOut(fsyncOut), .sdOut(sdOut),
  .txReady(txReady), .txStarve(txStarve), .rxData(rxData), .wordStb(wordStb)
);

// File: tb/tb_pcm_framer.sv
`timescale 1ns/1ps
module tb_pcm_framer;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        srcTickA = 1'b1, srcTickB;
  logic        srcSel = 0, sclkEn = 0, contClk = 0, txOn = 0, rxOn = 0, msbLate = 0;
  logic [8:0]  sclkDiv = 0, syncDiv = 31;
  logic [15:0] txData;
  logic        txValid = 0, txReady, txStarve, sdIn, wordStb, sclkOut, fsyncOut, sdOut;
  logic [15:0] rxData;
  logic        loop = 1'b1, rxConst = 1'b0;

  pcm_framer dut (
    .clk(clk), .rstN(rstN), .srcTickA(srcTickA), .srcTickB(srcTickB), .srcSel(srcSel),
    .sclkEn(sclkEn), .contClk(contClk), .txOn(txOn), .rxOn(rxOn), .msbLate(msbLate),
    .sclkDiv(sclkDiv), .syncDiv(syncDiv), .txData(txData), .txValid(txValid),
    .txReady(txReady), .txStarve(txStarve), .sdIn(sdIn), .rxData(rxData),
    .wordStb(wordStb), .sclkOut(sclkOut), .fsyncOut(fsyncOut), .sdOut(sdOut)
  );

  logic [15:0] words [64];
  int popCnt = 0;
  logic [1:0] cnt3 = 0;
  assign srcTickB = (cnt3 == 2'd0);
  assign txData = words[popCnt % 64];
  assign sdIn = loop ? sdOut : rxConst;

  always @(posedge clk) begin
    cnt3 <= (cnt3 == 2'd2) ? 2'd0 : cnt3 + 2'd1;
    if (!rstN) popCnt <= 0;
    else if (txReady) popCnt <= popCnt + 1;
  end

  int checks = 0, fails = 0;
  bit wdFired = 0;

  // observation results
  int rises, fsHigh, perBad, perAct, frameBad, frameAct, txBad, rxBad;
  int nTx, nRx, pops, starves;
  int txAct, txExp, rxAct, rxExp;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; sclkEn = 0; txOn = 0; rxOn = 0; contClk = 0; txValid = 0;
    loop = 1; rxConst = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
  endtask

  // txMode/rxMode: 0 no check, 1 word sequence, 2 zeros (tx) / all ones (rx)
  task automatic observe(int nCyc, int expPer, int expFrame, int late, int txMode, int rxMode);
    int cyc = 0, lastRise = -1, slot = 0, sinceFs = 0, nb = 0, txIdx = 0, rxIdx = 0;
    bit prev = sclkOut, seen = 0;
    logic [15:0] acc = 0, e;
    rises = 0; fsHigh = 0; perBad = 0; perAct = 0; frameBad = 0; frameAct = 0;
    txBad = 0; rxBad = 0; nTx = 0; nRx = 0; pops = 0; starves = 0;
    txAct = 0; txExp = 0; rxAct = 0; rxExp = 0;
    repeat (nCyc) begin
      @(negedge clk);
      cyc++;
      if (txReady) pops++;
      if (txStarve) starves++;
      if (sclkOut && !prev) begin
        rises++;
        if (lastRise >= 0 && cyc - lastRise != expPer) begin perBad++; perAct = cyc - lastRise; end
        lastRise = cyc;
        if (fsyncOut) begin
          fsHigh++;
          if (seen && sinceFs != expFrame) begin frameBad++; frameAct = sinceFs; end
          seen = 1; slot = 0; sinceFs = 1;
        end else begin
          slot++; sinceFs++;
        end
        if (seen && slot >= late && slot < late + 32) begin
          acc = {acc[14:0], sdOut}; nb++;
          if (nb == 16) begin
            e = (txMode == 1) ? words[txIdx % 64] : 16'h0;
            if (txMode != 0 && acc != e) begin txBad++; txAct = acc; txExp = e; end
            txIdx++; nTx++; nb = 0;
          end
        end
      end
      prev = sclkOut;
      if (wordStb) begin
        e = (rxMode == 1) ? words[rxIdx % 64] : 16'hFFFF;
        if (rxMode != 0 && rxData != e) begin rxBad++; rxAct = rxData; rxExp = e; end
        rxIdx++; nRx++;
      end
    end
  endtask

  function automatic int frameCyc(int frames, int sync, int per);
    return (frames * (sync + 1) + 4) * per + 20;
  endfunction

  task automatic dataRun(int div, int sync, bit late, bit sel, string tag);
    int per = 2 * (div + 1) * (sel ? 3 : 1);
    doReset();
    sclkDiv = 9'(div); syncDiv = 9'(sync); msbLate = late; srcSel = sel;
    txValid = 1; sclkEn = 1; txOn = 1; rxOn = 1;
    observe(frameCyc(4, sync, per), per, sync + 1, late, 1, 1);
    check(perBad == 0, sel ? "R2" : "R1", {tag, " bit clock period"}, perAct, per);
    check(frameBad == 0 && fsHigh >= 3, "R3", {tag, " frame length"}, frameAct, sync + 1);
    check(txBad == 0 && nTx >= 6, "R4", {tag, " serial words"}, txAct, txExp);
    check(pops >= 6, "R5", {tag, " words popped"}, pops, 6);
    check(rxBad == 0 && nRx >= 6, "R7", {tag, " received words"}, rxAct, rxExp);
  endtask

  task automatic runAll();
    doReset();
    @(negedge clk);
    check(sclkOut == 0 && fsyncOut == 0 && sdOut == 0 && wordStb == 0 && txReady == 0,
          "R1", "reset state", {sclkOut, fsyncOut, sdOut, wordStb, txReady}, 0);

    dataRun(1, 31, 0, 0, "early tight frame");
    dataRun(2, 32, 1, 0, "late tight frame");
    dataRun(0, 35, 0, 1, "source B");

    // R6 starve
    doReset();
    sclkDiv = 0; syncDiv = 33; msbLate = 0; srcSel = 0;
    txValid = 0; sclkEn = 1; txOn = 1; rxOn = 1;
    observe(frameCyc(3, 33, 2), 2, 34, 0, 2, 0);
    check(txBad == 0 && nTx >= 4, "R6", "starved words are zero", txAct, 0);
    check(starves >= 4 && pops == 0, "R6", "starve strobes without pop", pops, 0);

    // R10 receive only with constant input; tx side ignored
    doReset();
    sclkDiv = 1; syncDiv = 36; msbLate = 1; srcSel = 0; loop = 0; rxConst = 1;
    txValid = 1; sclkEn = 1; txOn = 0; rxOn = 1;
    observe(frameCyc(3, 36, 4), 4, 37, 1, 2, 2);
    check(rxBad == 0 && nRx >= 4, "R7", "receive-only words", rxAct, rxExp);
    check(pops == 0 && starves == 0 && txBad == 0, "R10", "tx off sends zeros, no pop", pops, 0);

    // R8 gate
    doReset();
    sclkDiv = 0; syncDiv = 31; txValid = 1; sclkEn = 0; txOn = 1; rxOn = 1;
    observe(400, 2, 32, 0, 0, 0);
    check(rises == 0 && fsHigh == 0 && sclkOut == 0, "R8", "clock gated off", rises, 0);

    // R9 idle behaviour
    doReset();
    sclkDiv = 0; syncDiv = 31; sclkEn = 1; contClk = 0;
    observe(400, 2, 32, 0, 0, 0);
    check(rises == 0, "R9", "idle clock stops", rises, 0);
    contClk = 1;
    observe(400, 2, 32, 0, 0, 0);
    check(rises > 100 && perBad == 0, "R9", "continuous idle clock", rises, 199);
    check(fsHigh == 0, "R9", "no sync while idle", fsHigh, 0);

    // R10 one direction off
    doReset();
    sclkDiv = 1; syncDiv = 33; msbLate = 0; txValid = 1; sclkEn = 1; txOn = 1; rxOn = 1;
    observe(frameCyc(2, 33, 4), 4, 34, 0, 1, 1);
    txOn = 0;
    observe(frameCyc(1, 33, 4), 4, 34, 0, 0, 0);
    observe(frameCyc(3, 33, 4), 4, 34, 0, 0, 0);
    check(perBad == 0 && frameBad == 0 && fsHigh >= 2, "R10", "rx keeps framing", fsHigh, 3);
    check(pops == 0 && nRx >= 4, "R10", "no pops after tx off", pops, 0);

    // constrained random configurations
    void'($urandom(32'd7));
    for (int i = 0; i < 6; i++) begin
      int d = $urandom_range(0, 3);
      int s = $urandom_range(32, 40);
      bit l = 1'($urandom_range(0, 1));
      bit b = 1'($urandom_range(0, 1));
      dataRun(d, s, l, b, "random");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) words[i] = 16'($urandom);
    words[0] = 16'h8001; words[1] = 16'hFFFF;
    fork
      runAll();
      begin #1000000; wdFired = 1; end
    join_any
    disable fork;
    if (wdFired) check(0, "WD", "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule